// File: doc/BRIEF.md
# Index Register Compare-Immediate Unit

This unit executes the two compare-immediate operations that act on an 8-bit index register. The register has two 4-bit halves: the high half (bits 7:4) and the low half (bits 3:0). A 12-bit instruction word arrives with a valid strobe. The unit decodes it and subtracts the 4-bit immediate from the selected half. From that subtraction it sets two flags: the borrow, which the unit calls carry, and zero. The register itself is never written by a compare.

Each compare occupies the unit for a fixed number of cycles, 7 by default. The unit shows this with a busy level and a one-cycle done pulse. Any other opcode raises a one-cycle illegal pulse and changes nothing.

A load port fills the index register while the unit is idle. A synchronous reset clears the register and all four flags.

Top module: `idx_cmp_unit`

## Requirements
- R1: While reset is high at a clock edge, the unit clears the index register, all four flags, busy, done and illegal to 0.
- R2: An accepted word with bits [11:4] equal to 8'hA4 compares the high half (x_reg[7:4]) against the immediate in bits [3:0].
- R3: An accepted word with bits [11:4] equal to 8'hA5 compares the low half (x_reg[3:0]) against the immediate in bits [3:0].
- R4: On completion, flag_c is 1 exactly when the selected half is less than the immediate, both taken as unsigned.
- R5: On completion, flag_z is 1 exactly when the selected half equals the immediate.
- R6: A compare leaves x_reg, flag_d and flag_i unchanged.
- R7: After the edge that accepts a compare, busy is high for EXEC_CYCLES cycles. done is high only in the last of those cycles. flag_c and flag_z keep their earlier values until that cycle and take the new result in it.
- R8: A valid word is accepted while the unit is idle. If bits [11:4] are neither 8'hA4 nor 8'hA5, the word produces an illegal pulse one cycle long in the following cycle. It starts no busy period and changes no flag or register.
- R9: load_en writes load_data into x_reg at the next edge only if the unit is idle. A load presented while busy is dropped.
- R10: A valid word presented while busy has no effect. It does not restart the count, it raises no illegal pulse, and it does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is present |
| instr | input | 12 | Instruction word |
| load_en | input | 1 | Write load_data into the index register |
| load_data | input | 8 | Value to load: high half in [7:4], low half in [3:0] |
| busy | output | 1 | A compare is executing |
| done | output | 1 | Last execution cycle; the new flags are visible |
| illegal | output | 1 | One-cycle pulse for an unsupported opcode |
| x_reg | output | 8 | Index register contents |
| flag_c | output | 1 | Carry (borrow) flag |
| flag_z | output | 1 | Zero flag |
| flag_d | output | 1 | Decimal-mode flag, never changed by a compare |
| flag_i | output | 1 | Interrupt-enable flag, never changed by a compare |

## Verification
The bench builds the unit with its default EXEC_CYCLES of 7. This keeps every compare short enough to sweep all 256 register values against all 32 legal opcodes, so every immediate, both halves and every less/equal/greater case is covered. With the same short period, all 4064 unsupported opcodes can be presented one by one. During every compare, a load and a stray instruction are injected mid-execution to show that both are dropped.

// File: rtl/idx_cmp_unit.sv
module idx_cmp_unit #(
  parameter int EXEC_CYCLES = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        instr_valid,
  input  logic [11:0] instr,
  input  logic        load_en,
  input  logic [7:0]  load_data,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic [7:0]  x_reg,
  output logic        flag_c,
  output logic        flag_z,
  output logic        flag_d,
  output logic        flag_i
);
  localparam int CW = $clog2(EXEC_CYCLES + 1);
  localparam logic [7:0] OP_HI = 8'hA4;
  localparam logic [7:0] OP_LO = 8'hA5;

  logic [CW-1:0] cnt;
  logic          sel_lo;
  logic [3:0]    imm;

  wire       take  = instr_valid && !busy;
  wire       legal = (instr[11:4] == OP_HI) || (instr[11:4] == OP_LO);
  wire [3:0] nib   = sel_lo ? x_reg[3:0] : x_reg[7:4];
  wire       last  = cnt == CW'(EXEC_CYCLES);

  assign done = busy && last;

  // flags are written on the edge that enters the final cycle (EXEC_CYCLES >= 2)
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      illegal <= 1'b0;
      x_reg   <= '0;
      flag_c  <= 1'b0;
      flag_z  <= 1'b0;
      flag_d  <= 1'b0;
      flag_i  <= 1'b0;
      cnt     <= '0;
      sel_lo  <= 1'b0;
      imm     <= '0;
    end else begin
      illegal <= take && !legal;
      if (load_en && !busy) x_reg <= load_data;
      if (take && legal) begin
        busy   <= 1'b1;
        cnt    <= CW'(1);
        sel_lo <= instr[4];
        imm    <= instr[3:0];
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + 1'b1;
        if (cnt == CW'(EXEC_CYCLES - 1)) begin
          flag_c <= nib < imm;
          flag_z <= nib == imm;
        end
      end
    end
  end
endmodule

// File: rtl/idx_cmp_unit_chk.sv
module idx_cmp_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       illegal,
  input logic [7:0] x_reg,
  input logic       flag_c,
  input logic       flag_z
);
  // R7
  done_in_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> busy);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  flags_move_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({flag_c, flag_z}) |-> done);
  // R6
  x_held_busy_chk: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(x_reg));
  // R8
  illegal_idle_chk: assert property (@(posedge clk) disable iff (rst) illegal |-> !busy);
  // R8
  illegal_single_chk: assert property (@(posedge clk) disable iff (rst) illegal |=> !illegal);
endmodule

bind idx_cmp_unit idx_cmp_unit_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .illegal(illegal),
  .x_reg(x_reg), .flag_c(flag_c), .flag_z(flag_z)
);

// File: tb/sim_idx_cmp_unit.sv
`timescale 1ns/1ps
module sim_idx_cmp_unit;
  localparam int CYC = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_valid = 1'b0;
  logic [11:0] instr = '0;
  logic load_en = 1'b0;
  logic [7:0] load_data = '0;
  logic busy, done, illegal, flag_c, flag_z, flag_d, flag_i;
  logic [7:0] x_reg;

  int runs = 0;
  int fails = 0;
  logic ec = 1'b0, ez = 1'b0;

  always #2 clk = ~clk;

  idx_cmp_unit #(.EXEC_CYCLES(CYC)) u0 (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .load_en(load_en), .load_data(load_data), .busy(busy), .done(done),
    .illegal(illegal), .x_reg(x_reg), .flag_c(flag_c), .flag_z(flag_z),
    .flag_d(flag_d), .flag_i(flag_i)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cmp(input logic [7:0] xv, input logic [11:0] op);
    logic [3:0] nb, im;
    bit tim_ok, busy_ok;
    @(negedge clk);
    load_en = 1'b1; load_data = xv;
    @(negedge clk);
    load_en = 1'b0;
    check(x_reg == xv, "R9 idle load", x_reg, xv);
    instr_valid = 1'b1; instr = op;
    @(negedge clk);
    instr_valid = 1'b0;
    tim_ok = 1'b1; busy_ok = 1'b1;
    for (int k = 1; k <= CYC; k++) begin
      if (k < CYC) begin
        if (!(busy && !done && flag_c == ec && flag_z == ez)) tim_ok = 1'b0;
      end
      if (k == 3) begin
        // R9/R10: load and stray word while busy
        load_en = 1'b1; load_data = ~xv; instr_valid = 1'b1; instr = 12'hFFF;
      end
      if (k == 4) begin
        load_en = 1'b0; instr_valid = 1'b0;
        if (illegal) busy_ok = 1'b0;
      end
      if (k == CYC) begin
        if (!(busy && done)) tim_ok = 1'b0;
        nb = op[4] ? xv[3:0] : xv[7:4];
        im = op[3:0];
        ec = nb < im;
        ez = nb == im;
        check(flag_c == ec, op[4] ? "R3/R4 low carry" : "R2/R4 high carry", flag_c, ec);
        check(flag_z == ez, op[4] ? "R3/R5 low zero" : "R2/R5 high zero", flag_z, ez);
        check(x_reg == xv && !flag_d && !flag_i, "R6/R9 state held", x_reg, xv);
      end
      @(negedge clk);
    end
    if (busy || done) tim_ok = 1'b0;
    check(tim_ok, "R7 busy/done timing", {busy, done}, 0);
    check(busy_ok, "R10 word while busy", 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(x_reg == 0 && !flag_c && !flag_z && !flag_d && !flag_i && !busy && !done && !illegal,
          "R1 reset state", {x_reg, flag_c, flag_z, busy}, 0);

    for (int x = 0; x < 256; x++)
      for (int o = 0; o < 32; o++)
        run_cmp(8'(x), 12'hA40 + 12'(o));

    run_cmp(8'h5A, 12'hA40);
    for (int op = 0; op < 4096; op++) begin
      if (op >= 12'hA40 && op <= 12'hA5F) continue;
      @(negedge clk);
      instr_valid = 1'b1; instr = 12'(op);
      @(negedge clk);
      instr_valid = 1'b0;
      check(illegal && !busy, "R8 illegal pulse", {illegal, busy}, 2);
      @(negedge clk);
      check(!illegal && !busy && x_reg == 8'h5A && flag_c == ec && flag_z == ez,
            "R8 no state change", {illegal, x_reg, flag_c, flag_z}, {1'b0, 8'h5A, ec, ez});
    end

    run_cmp(8'h3F, 12'hA5F);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(x_reg == 0 && !flag_c && !flag_z && !busy && !illegal, "R1 reset clears",
          {x_reg, flag_c, flag_z}, 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule